// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of hardware pins, a non-maskable input, a watchdog line and four software-set slots. It turns them into a single request to the processor, with a vector that identifies the source. Each hardware pin is synchronized and then detected by its own small unit. That unit can be set to follow the pin's level or to latch an edge, and either sense can be chosen as the active one. Every maskable source holds a 3-bit priority. A combinational resolver picks the most urgent pending source, and that winner is then weighed against the processor's mask level and global enable.

A registered output stage presents the request and its vector. The vector stays frozen for as long as the request line is high. When the winner changes or disappears, the stage drops the request for one cycle and then reloads it. Two side outputs are also provided. The first is a wake-up flag driven only by a fixed subset of pins. The second is a one-cycle DMA trigger per pin, and it does not depend on the pin's priority.

Software programs each source through an indexed configuration write. It can also clear an edge-latched request by writing the source's index to a clear port. The four software slots are set and cleared through a third write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A level-mode pin is pending while its synchronized input equals its polarity bit: polarity 1 means active high, polarity 0 means active low. The request appears at the output no more than 8 cycles after the pin changes.
- R2: An edge-mode pin latches a pending flag on a rising edge when its polarity is 1, or on a falling edge when its polarity is 0. The flag stays set after the pin returns, and an edge of the opposite sense does nothing.
- R3: Among maskable pending sources, the highest priority wins, and on a tie the lower source index wins. Priority 0 never produces a processor request.
- R4: A maskable winner is delivered only while core_ie is 1 and its priority is strictly greater than core_mask.
- R5: The source indices are as follows: NMI is 0, the watchdog is 1, hardware pin i is 2+i, and software slot j is 2+N_HW+j. irq_vec equals the index shifted left by 4, and it does not change while irq_req stays high.
- R6: A clear write with an index clears that source's edge-latched or software flag. It has no effect on level-mode pins. An edge event in the same cycle as a clear of the same source keeps the flag set.
- R7: The NMI and watchdog inputs latch on a rising edge and ignore core_ie and core_mask. They are delivered ahead of every maskable source, with NMI first, and irq_nmi is 1 while such a request is presented.
- R8: Software slot j is set by a write with sw_set=1 and cleared by sw_set=0, or by the clear port. It arbitrates with the priority in the low 3 bits of its configuration.
- R9: wake_req is 1 while any pending pin has its wake bit set and is also in WAKE_MASK (by default, pins 0 to 4 and pin 9). All other pins never raise it.
- R10: dma_trig[i] pulses for one cycle each time pin i's pending flag goes from 0 to 1 while its DMA bit is set, whatever the pin's priority.
- R11: After reset, irq_req, irq_nmi, irq_vec, wake_req and dma_trig are all 0, and every source has priority 0, level mode and polarity 1.
- R12: The configuration word is laid out as follows: [2:0] priority, [3] polarity, [4] edge mode, [5] DMA enable, [6] wake enable. A write to index 0 or 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | N_HW | Hardware interrupt pins, asynchronous |
| nmi_pin | input | 1 | Non-maskable request, rising edge |
| wdt_irq | input | 1 | Watchdog request, rising edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Source index of the configuration write |
| cfg_data | input | 7 | Configuration word (layout in R12) |
| clr_we | input | 1 | Clear write strobe |
| clr_idx | input | IW | Source index to clear |
| sw_we | input | 1 | Software slot write strobe |
| sw_idx | input | SWW | Software slot number |
| sw_set | input | 1 | 1 sets, 0 clears the slot |
| core_mask | input | 3 | Processor mask level |
| core_ie | input | 1 | Processor global enable |
| irq_req | output | 1 | Request to the processor |
| irq_vec | output | VW | Vector (index << 4) |
| irq_nmi | output | 1 | Presented request is non-maskable |
| wake_req | output | 1 | Low-power wake-up indication |
| dma_trig | output | N_HW | Per-pin DMA trigger pulse |

## Verification
Two functions can land in the same cycle: a clear write, and a new active edge on the same edge-mode pin. The bench first latches an edge on a pin and lets the pin fall. It then raises the pin again and places the clear strobe on exactly the clock edge at which the synchronized edge is captured. A correct design keeps the request with that pin's vector, while a design that gives priority to the clear loses it. A second collision is also driven: the NMI and watchdog rise together while a software request is pending. The bench then judges the order in which their vectors appear as each is cleared.

// File: rtl/pic_pkg.sv
package pic_pkg;

   localparam int PRIO_W    = 3;
   localparam int VEC_SHIFT = 4;
   localparam int SYS_SRCS  = 2;

   typedef struct packed {
      logic              wake_en;
      logic              dma_en;
      logic              edge_md;
      logic              pol;
      logic [PRIO_W-1:0] prio;
   } src_cfg_t;

   localparam int CFG_W = $bits(src_cfg_t);

   localparam src_cfg_t CFG_RST = '{wake_en: 1'b0, dma_en: 1'b0, edge_md: 1'b0,
                                    pol: 1'b1, prio: '0};

endpackage

// File: rtl/pic_src_det.sv
module pic_src_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic pol,
   input  logic edge_md,
   input  logic clr,
   output logic pend
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   s_in;
   logic                   evt;
   logic                   pend_d;

   initial begin
      if (SYNC_STAGES < 2) $error("pic_src_det: SYNC_STAGES must be at least 2");
   end

   assign s_in = sync_q[SYNC_STAGES-1];

   // active edge in the sense chosen by the polarity bit
   assign evt = pol ? (s_in & ~prev_q) : (~s_in & prev_q);

   // a fresh edge outranks a clear arriving in the same cycle
   assign pend_d = edge_md ? (evt | (pend & ~clr)) : (s_in == pol);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
         pend   <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
         prev_q <= s_in;
         pend   <= pend_d;
      end
   end

endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
   import pic_pkg::*;
#(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic [N-1:0]        req,
   input  logic [N*PRIO_W-1:0] prio_flat,
   output logic                win_v,
   output logic [IW-1:0]       win_idx,
   output logic [PRIO_W-1:0]   win_prio
);

   initial begin
      if ((1 << IW) < N) $error("pic_resolve: IW too narrow for N");
   end

   // strict compare keeps the lowest index on a tie and drops priority 0
   always_comb begin
      win_v    = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
            win_v    = 1'b1;
            win_idx  = IW'(i);
            win_prio = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/pic_out_stage.sv
module pic_out_stage #(
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cand_v,
   input  logic [IW-1:0] cand_idx,
   input  logic          cand_nmi,
   output logic          req_q,
   output logic [IW-1:0] idx_q,
   output logic          nmi_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         idx_q <= '0;
         nmi_q <= 1'b0;
      end else if (!req_q) begin
         req_q <= cand_v;
         if (cand_v) begin
            idx_q <= cand_idx;
            nmi_q <= cand_nmi;
         end
      end else if (!(cand_v && (cand_idx == idx_q))) begin
         // winner changed or vanished: drop for a cycle, keep vector frozen
         req_q <= 1'b0;
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int              N_HW        = 10,
   parameter int              N_SW        = 4,
   parameter int              SYNC_STAGES = 2,
   parameter logic [N_HW-1:0] WAKE_MASK   = 10'b10_0001_1111,
   localparam int             N_TOT       = N_HW + N_SW + SYS_SRCS,
   localparam int             IW          = $clog2(N_TOT),
   localparam int             VW          = IW + VEC_SHIFT,
   localparam int             SWW         = (N_SW > 1) ? $clog2(N_SW) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_HW-1:0]   irq_pins,
   input  logic              nmi_pin,
   input  logic              wdt_irq,
   input  logic              cfg_we,
   input  logic [IW-1:0]     cfg_idx,
   input  logic [CFG_W-1:0]  cfg_data,
   input  logic              clr_we,
   input  logic [IW-1:0]     clr_idx,
   input  logic              sw_we,
   input  logic [SWW-1:0]    sw_idx,
   input  logic              sw_set,
   input  logic [PRIO_W-1:0] core_mask,
   input  logic              core_ie,
   output logic              irq_req,
   output logic [VW-1:0]     irq_vec,
   output logic              irq_nmi,
   output logic              wake_req,
   output logic [N_HW-1:0]   dma_trig
);

   localparam int HW_BASE = SYS_SRCS;
   localparam int SW_BASE = SYS_SRCS + N_HW;

   initial begin
      if (N_HW < 1) $error("prio_irq_ctrl: N_HW must be at least 1");
      if (N_SW < 1) $error("prio_irq_ctrl: N_SW must be at least 1");
   end

   logic [N_TOT-1:0]        pend;
   logic [N_TOT*PRIO_W-1:0] prio_flat;
   logic [N_HW-1:0]         wake_vec;

   logic                    win_v;
   logic [IW-1:0]           win_idx;
   logic [PRIO_W-1:0]       win_prio;
   logic                    cand_v;
   logic [IW-1:0]           cand_idx;
   logic                    cand_nmi;
   logic                    out_req;
   logic [IW-1:0]           out_idx;
   logic                    out_nmi;

   // non-maskable and watchdog: fixed rising-edge detection
   logic [SYS_SRCS-1:0] sys_raw;
   assign sys_raw = {wdt_irq, nmi_pin};

   for (genvar k = 0; k < SYS_SRCS; k++) begin : g_sys
      pic_src_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw     (sys_raw[k]),
         .pol     (1'b1),
         .edge_md (1'b1),
         .clr     (clr_we && (clr_idx == IW'(k))),
         .pend    (pend[k])
      );
      assign prio_flat[k*PRIO_W +: PRIO_W] = '0;
   end

   // hardware pins
   for (genvar i = 0; i < N_HW; i++) begin : g_hw
      src_cfg_t cfg_q;
      logic     hist_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_q  <= CFG_RST;
            hist_q <= 1'b0;
         end else begin
            if (cfg_we && (cfg_idx == IW'(HW_BASE + i))) cfg_q <= src_cfg_t'(cfg_data);
            hist_q <= pend[HW_BASE+i];
         end
      end

      pic_src_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw     (irq_pins[i]),
         .pol     (cfg_q.pol),
         .edge_md (cfg_q.edge_md),
         .clr     (clr_we && (clr_idx == IW'(HW_BASE + i))),
         .pend    (pend[HW_BASE+i])
      );

      assign prio_flat[(HW_BASE+i)*PRIO_W +: PRIO_W] = cfg_q.prio;
      assign dma_trig[i] = cfg_q.dma_en & pend[HW_BASE+i] & ~hist_q;
      assign wake_vec[i] = WAKE_MASK[i] & cfg_q.wake_en & pend[HW_BASE+i];
   end

   // software slots
   for (genvar j = 0; j < N_SW; j++) begin : g_sw
      logic [PRIO_W-1:0] prio_q;
      logic              pend_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prio_q <= '0;
            pend_q <= 1'b0;
         end else begin
            if (cfg_we && (cfg_idx == IW'(SW_BASE + j))) prio_q <= cfg_data[PRIO_W-1:0];
            if (sw_we && (sw_idx == SWW'(j)))                  pend_q <= sw_set;
            else if (clr_we && (clr_idx == IW'(SW_BASE + j)))  pend_q <= 1'b0;
         end
      end

      assign pend[SW_BASE+j] = pend_q;
      assign prio_flat[(SW_BASE+j)*PRIO_W +: PRIO_W] = prio_q;
   end

   pic_resolve #(.N(N_TOT), .IW(IW)) u_resolve (
      .req       (pend),
      .prio_flat (prio_flat),
      .win_v     (win_v),
      .win_idx   (win_idx),
      .win_prio  (win_prio)
   );

   assign cand_nmi = pend[0] | pend[1];
   assign cand_v   = cand_nmi | (win_v & core_ie & (win_prio > core_mask));
   assign cand_idx = pend[0] ? IW'(0) : (pend[1] ? IW'(1) : win_idx);

   pic_out_stage #(.IW(IW)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand_v   (cand_v),
      .cand_idx (cand_idx),
      .cand_nmi (cand_nmi),
      .req_q    (out_req),
      .idx_q    (out_idx),
      .nmi_q    (out_nmi)
   );

   assign irq_req  = out_req;
   assign irq_vec  = {out_idx, {VEC_SHIFT{1'b0}}};
   assign irq_nmi  = out_req & out_nmi;
   assign wake_req = |wake_vec;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int VW   = 8,
   parameter int N_HW = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            core_ie,
   input logic            irq_req,
   input logic            irq_nmi,
   input logic [VW-1:0]   irq_vec,
   input logic [N_HW-1:0] dma_trig
);

   // R5: vector frozen while the request stays up
   a_r5_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && $past(irq_req)) |-> $stable(irq_vec));

   // R4: a maskable request only follows a cycle with the enable set
   a_r4_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_nmi) |-> $past(core_ie));

   // R7: a non-maskable request always carries index 0 or 1
   a_r7_nmi_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_nmi) |-> (irq_vec < VW'(32)));

   // R10: a trigger never lasts two cycles
   a_r10_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> !(|(dma_trig & $past(dma_trig))));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.VW(VW), .N_HW(N_HW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .core_ie  (core_ie),
   .irq_req  (irq_req),
   .irq_nmi  (irq_nmi),
   .irq_vec  (irq_vec),
   .dma_trig (dma_trig)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] irq_pins = 10'b00_0000_0010;
   logic       nmi_pin = 1'b0;
   logic       wdt_irq = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_idx = '0;
   logic [6:0] cfg_data = '0;
   logic       clr_we = 1'b0;
   logic [3:0] clr_idx = '0;
   logic       sw_we = 1'b0;
   logic [1:0] sw_idx = '0;
   logic       sw_set = 1'b0;
   logic [2:0] core_mask = '0;
   logic       core_ie = 1'b1;
   logic       irq_req;
   logic [7:0] irq_vec;
   logic       irq_nmi;
   logic       wake_req;
   logic [9:0] dma_trig;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;
   int dma_cnt [10];

   always #10 clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .nmi_pin(nmi_pin), .wdt_irq(wdt_irq),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .clr_we(clr_we), .clr_idx(clr_idx), .sw_we(sw_we), .sw_idx(sw_idx), .sw_set(sw_set),
      .core_mask(core_mask), .core_ie(core_ie), .irq_req(irq_req), .irq_vec(irq_vec),
      .irq_nmi(irq_nmi), .wake_req(wake_req), .dma_trig(dma_trig)
   );

   always @(posedge clk) begin
      for (int i = 0; i < 10; i++) begin
         if (!rst_n) dma_cnt[i] <= 0;
         else if (dma_trig[i]) dma_cnt[i] <= dma_cnt[i] + 1;
      end
   end

   // {pins[3:0], mask, ie, expected req, expected index}
   localparam logic [12:0] TBL [12] = '{
      {4'b0010, 3'd0, 1'b1, 1'b0, 4'd0},
      {4'b0011, 3'd0, 1'b1, 1'b1, 4'd2},
      {4'b0011, 3'd3, 1'b1, 1'b0, 4'd0},
      {4'b0011, 3'd2, 1'b1, 1'b1, 4'd2},
      {4'b0011, 3'd0, 1'b0, 1'b0, 4'd0},
      {4'b0000, 3'd0, 1'b1, 1'b1, 4'd3},
      {4'b0100, 3'd0, 1'b1, 1'b1, 4'd3},
      {4'b0110, 3'd0, 1'b1, 1'b1, 4'd4},
      {4'b1101, 3'd0, 1'b1, 1'b1, 4'd5},
      {4'b1010, 3'd6, 1'b1, 1'b1, 4'd5},
      {4'b1010, 3'd7, 1'b1, 1'b0, 4'd0},
      {4'b0101, 3'd4, 1'b1, 1'b1, 4'd3}
   };

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfg(input int idx, input logic [6:0] d);
      cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_data = d;
      cyc(1);
      cfg_we = 1'b0;
   endtask

   task automatic clr(input int idx);
      clr_we = 1'b1; clr_idx = 4'(idx);
      cyc(1);
      clr_we = 1'b0;
   endtask

   task automatic swr(input int j, input logic v);
      sw_we = 1'b1; sw_idx = 2'(j); sw_set = v;
      cyc(1);
      sw_we = 1'b0;
   endtask

   initial begin
      int c;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R11 req after reset", int'(irq_req), 0);
      chk("R11 vec after reset", int'(irq_vec), 0);
      chk("R11 wake after reset", int'(wake_req), 0);
      chk("R11 dma after reset", int'(dma_trig), 0);

      cfg(0, 7'h0F);                 // ignored (R12)
      cfg(2, 7'h0B); cfg(3, 7'h05); cfg(4, 7'h0D); cfg(5, 7'h0F);
      cfg(6, 7'h7A); cfg(7, 7'h74); cfg(8, 7'h28); cfg(11, 7'h49);
      cfg(12, 7'h06); cfg(15, 7'h01);
      cyc(8);
      chk("R12 idle after config", int'(irq_req), 0);

      for (int e = 0; e < 12; e++) begin
         irq_pins[3:0] = TBL[e][12:9];
         core_mask     = TBL[e][8:6];
         core_ie       = TBL[e][5];
         cyc(8);
         chk($sformatf("R4 table %0d req", e), int'(irq_req), int'(TBL[e][4]));
         if (TBL[e][4])
            chk($sformatf("R3 table %0d vec", e), int'(irq_vec), int'(TBL[e][3:0]) << 4);
      end
      irq_pins[3:0] = 4'b0010; core_mask = 3'd0; core_ie = 1'b1;
      cyc(8);
      chk("R1 active-low pin idle high", int'(irq_req), 0);

      // level follows pin, clear ignored
      irq_pins[0] = 1'b1; cyc(8);
      chk("R1 level high asserts", int'(irq_vec), 8'h20);
      clr(2); cyc(8);
      chk("R6 level not clearable", int'(irq_req), 1);
      irq_pins[0] = 1'b0; cyc(8);
      chk("R1 level drop releases", int'(irq_req), 0);

      // rising edge source with wake and dma
      c = dma_cnt[4];
      irq_pins[4] = 1'b1; cyc(8);
      chk("R2 rising edge vec", int'(irq_vec), 8'h60);
      chk("R9 wake from pin4", int'(wake_req), 1);
      chk("R10 dma pulse pin4", dma_cnt[4] - c, 1);
      irq_pins[4] = 1'b0; cyc(8);
      chk("R2 edge latched after pin low", int'(irq_req), 1);
      clr(6); cyc(8);
      chk("R6 clear edge pending", int'(irq_req), 0);
      chk("R9 wake gone after clear", int'(wake_req), 0);

      // collision: clear on the cycle the new edge is captured
      irq_pins[4] = 1'b1; cyc(8);
      irq_pins[4] = 1'b0; cyc(8);
      c = dma_cnt[4];
      irq_pins[4] = 1'b1;
      cyc(2);
      clr_we = 1'b1; clr_idx = 4'd6;
      cyc(1);
      clr_we = 1'b0;
      cyc(4);
      chk("R6 edge beats clear req", int'(irq_req), 1);
      chk("R6 edge beats clear vec", int'(irq_vec), 8'h60);
      chk("R10 no extra pulse while pending", dma_cnt[4] - c, 0);
      irq_pins[4] = 1'b0;
      clr(6); cyc(8);
      chk("R6 final clear", int'(irq_req), 0);

      // falling edge source, not wake-capable
      c = dma_cnt[5];
      irq_pins[5] = 1'b1; cyc(8);
      chk("R2 rise ignored on falling source", int'(irq_req), 0);
      irq_pins[5] = 1'b0; cyc(8);
      chk("R2 falling edge vec", int'(irq_vec), 8'h70);
      chk("R9 pin5 never wakes", int'(wake_req), 0);
      chk("R10 dma pulse pin5", dma_cnt[5] - c, 1);
      clr(7); cyc(8);
      chk("R6 clear falling source", int'(irq_req), 0);

      // dma only, priority 0
      c = dma_cnt[6];
      irq_pins[6] = 1'b1; cyc(8);
      chk("R10 dma with priority 0", dma_cnt[6] - c, 1);
      chk("R3 priority 0 no request", int'(irq_req), 0);
      irq_pins[6] = 1'b0; cyc(8);

      // wake-capable level pin 9
      irq_pins[9] = 1'b1; cyc(8);
      chk("R9 wake from pin9", int'(wake_req), 1);
      chk("R3 pin9 vec", int'(irq_vec), 8'hB0);
      irq_pins[9] = 1'b0; cyc(8);
      chk("R9 wake drops with pin9", int'(wake_req), 0);

      // software slots
      swr(0, 1'b1); cyc(8);
      chk("R8 sw0 vec", int'(irq_vec), 8'hC0);
      swr(3, 1'b1); cyc(8);
      chk("R8 sw0 outranks sw3", int'(irq_vec), 8'hC0);
      swr(0, 1'b0); cyc(8);
      chk("R8 sw3 after sw0 cleared", int'(irq_vec), 8'hF0);
      clr(15); cyc(8);
      chk("R8 clear port on sw3", int'(irq_req), 0);

      // non-maskable and watchdog
      swr(0, 1'b1);
      core_ie = 1'b0; cyc(8);
      chk("R4 ie low blocks sw0", int'(irq_req), 0);
      nmi_pin = 1'b1; wdt_irq = 1'b1; cyc(8);
      chk("R7 nmi first vec", int'(irq_vec), 8'h00);
      chk("R7 nmi flag", int'(irq_nmi), 1);
      chk("R7 nmi req despite ie", int'(irq_req), 1);
      clr(0); cyc(8);
      chk("R7 watchdog next", int'(irq_vec), 8'h10);
      chk("R7 watchdog flag", int'(irq_nmi), 1);
      clr(1); cyc(8);
      chk("R4 nothing with ie low", int'(irq_req), 0);
      core_ie = 1'b1; cyc(8);
      chk("R5 sw0 vector back", int'(irq_vec), 8'hC0);
      chk("R7 flag clear for maskable", int'(irq_nmi), 0);
      nmi_pin = 1'b0; wdt_irq = 1'b0;
      core_mask = 3'd7; cyc(8);
      chk("R4 mask 7 blocks sw0", int'(irq_req), 0);
      nmi_pin = 1'b1; cyc(8);
      chk("R7 nmi ignores mask", int'(irq_req), 1);
      chk("R7 nmi vec under mask", int'(irq_vec), 8'h00);
      clr(0); cyc(8);
      chk("R4 masked after nmi cleared", int'(irq_req), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog R11 act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule